// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is the write side of a three-wire control port. A host lowers a select line, clocks sixteen bits into a data pin on rising edges of a serial clock, and raises select again. The frame carries a three-bit opcode, a five-bit register address and an eight-bit value. The address and the value are each sent least significant bit first. The block holds four eight-bit configuration registers. It updates the addressed one only when select is released, and only if the frame was well formed and the register is open for writing in the current state.

Writes are gated by state. While the hardware reset is asserted, every register sits at its reset value and nothing can be written. Releasing reset starts an offset-calibration window that lasts a fixed number of sample periods, counted on a one-cycle sample tick. During that window the power register refuses writes. Two power bits in that register then decide whether the converter-mode register and the gain register accept writes. The serial pins are asynchronous to the system clock and pass through two-flop synchronisers before their edges are detected.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is sent as opcode bits o0,o1,o2, then address bits a0..a4, then data bits d0..d7, one bit per rising serial-clock edge. The address a4..a0 selects the register and d7..d0 becomes its new value.
- R2: A register changes only after the synchronised select line rises. With all sixteen bits clocked in and select still low, every register keeps its previous value.
- R3: A frame is committed only if exactly 16 rising serial-clock edges occurred while select was low. A frame with 15 or 17 edges changes no register.
- R4: The frame is a write only when o2 is 1. Values of o0 and o1 have no effect. A frame with o2 = 0 changes no register.
- R5: Only addresses 0 to 3 are writable. A frame addressed to 4..31 leaves all four registers unchanged.
- R6: While reset is asserted, and right after it is released, the registers read 0x05, 0x03, 0x30, 0x00 for addresses 0..3.
- R7: After reset is released, calActive is 1 until CAL_PERIODS sample ticks have been counted (default 4128), and it drops on the clock of the last tick. While calActive is 1, writes to address 1 are refused and other addresses stay writable. Once it is 0, address 1 is writable.
- R8: Writes to address 2 are refused while bit 1 of register 1 (converter power) is 0.
- R9: Writes to address 3 are refused while bit 0 of register 1 (gain-stage power) is 0.
- R10: Serial-clock edges while select is high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| sampleTick | input | 1 | One-cycle pulse per sample period |
| csN | input | 1 | Serial select, active low, high when idle |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data input |
| cfgReg0 | output | 8 | Register at address 0 |
| cfgReg1 | output | 8 | Register at address 1 (bit 1 converter power, bit 0 gain power) |
| cfgReg2 | output | 8 | Register at address 2 |
| cfgReg3 | output | 8 | Register at address 3 |
| calActive | output | 1 | High during the post-reset calibration window |

## Verification
A rising edge on csN reaches the synchroniser output after two system clocks. It is compared with the previous value on the third clock, and the register write lands on that same third clock. The bench therefore holds select low with the data steady, checks that nothing has changed, then raises select and waits ten clocks before it compares the registers with its own model. calActive falls on the clock that counts the final sample tick. The bench counts ticks the same way and samples at the falling edge one tick before that point and again on the final tick. Each serial bit is held for four clocks on each side of a rising serial-clock edge, so the synchronised data is stable when it is shifted in.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  localparam int REG_COUNT  = 4;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  localparam int OP_W       = 3;
  localparam int FRAME_BITS = OP_W + ADDR_W + DATA_W;
  // the first OP_W-1 opcode bits are don't-care and are shifted out
  localparam int KEEP_BITS  = FRAME_BITS - (OP_W - 1);
  localparam int SEL_W      = $clog2(REG_COUNT);

  localparam int CAL_ADDR       = 1;
  localparam int ADC_GATED_ADDR = 2;
  localparam int PGA_GATED_ADDR = 3;
  localparam int PWR_REG        = 1;
  localparam int PWR_ADC_BIT    = 1;
  localparam int PWR_PGA_BIT    = 0;

  typedef logic [DATA_W-1:0] cfgByte_t;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic frameDone;
    logic calBusy;
  } ctlStrobe_t;

  function automatic cfgByte_t resetValue(input int idx);
    case (idx)
      0:       return 8'h05;
      1:       return 8'h03;
      2:       return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/serial_cfg_ctrl.sv
module serial_cfg_ctrl
  import serial_cfg_pkg::*;
#(
  parameter int CAL_PERIODS = 4128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output ctlStrobe_t strobe
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam int CAL_W = $clog2(CAL_PERIODS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_PERIODS - 1);

  logic [SYNC_STAGES-1:0] csSync, sclkSync, sdiSync;
  logic csLast, sclkLast;
  logic csNow, sclkNow, sdiNow;
  logic csRise, csFall, sclkRise;
  logic [CNT_W-1:0] bitCnt;
  logic [CAL_W-1:0] calCnt;
  logic calBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= '1;
      sclkSync <= '0;
      sdiSync  <= '0;
      csLast   <= 1'b1;
      sclkLast <= 1'b0;
    end else begin
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      sdiSync  <= {sdiSync[SYNC_STAGES-2:0], sdi};
      csLast   <= csSync[SYNC_STAGES-1];
      sclkLast <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign csNow    = csSync[SYNC_STAGES-1];
  assign sclkNow  = sclkSync[SYNC_STAGES-1];
  assign sdiNow   = sdiSync[SYNC_STAGES-1];
  assign csRise   = csNow & ~csLast;
  assign csFall   = ~csNow & csLast;
  assign sclkRise = sclkNow & ~sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
    end else if (sclkRise && !csNow && bitCnt != CNT_SAT) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calBusy <= 1'b1;
      calCnt  <= '0;
    end else if (calBusy && sampleTick) begin
      if (calCnt == CAL_LAST) calBusy <= 1'b0;
      else                    calCnt  <= calCnt + 1'b1;
    end
  end

  assign strobe.shiftEn   = sclkRise & ~csNow;
  assign strobe.shiftBit  = sdiNow;
  assign strobe.frameDone = csRise && (bitCnt == CNT_FULL);
  assign strobe.calBusy   = calBusy;

  // R3
  bit_count_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_SAT);

  // R2
  commit_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameDone |=> !strobe.frameDone);

  // R7
  cal_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calBusy) |-> $past(sampleTick));

  // R7
  cal_never_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(calBusy));

endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
  import serial_cfg_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  ctlStrobe_t                       strobe,
  output logic [REG_COUNT-1:0][DATA_W-1:0] bankQ
);

  logic [KEEP_BITS-1:0] shiftReg;
  logic                 isWrite;
  logic [ADDR_W-1:0]    frameAddr;
  cfgByte_t             frameData;
  logic [SEL_W-1:0]     selIdx;
  logic                 inRange;
  logic [REG_COUNT-1:0] permit;
  logic [REG_COUNT-1:0] wrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {strobe.shiftBit, shiftReg[KEEP_BITS-1:1]};
  end

  assign isWrite   = shiftReg[0];
  assign frameAddr = shiftReg[1 +: ADDR_W];
  assign frameData = shiftReg[1 + ADDR_W +: DATA_W];
  assign selIdx    = frameAddr[SEL_W-1:0];
  assign inRange   = (frameAddr[ADDR_W-1:SEL_W] == '0);

  always_comb begin
    for (int i = 0; i < REG_COUNT; i++) begin
      if (i == CAL_ADDR)            permit[i] = ~strobe.calBusy;
      else if (i == ADC_GATED_ADDR) permit[i] = bankQ[PWR_REG][PWR_ADC_BIT];
      else if (i == PGA_GATED_ADDR) permit[i] = bankQ[PWR_REG][PWR_PGA_BIT];
      else                          permit[i] = 1'b1;
    end
  end

  always_comb begin
    wrEn = '0;
    if (strobe.frameDone && isWrite && inRange) wrEn[selIdx] = permit[selIdx];
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        bankQ[g] <= resetValue(g);
      else if (wrEn[g]) bankQ[g] <= frameData;
    end
  end

  // R2
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameDone |=> $stable(bankQ));

  // R4
  read_opcode_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && !isWrite) |=> $stable(bankQ));

  // R5
  high_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && !inRange) |=> $stable(bankQ));

  // R8
  adc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && frameAddr == ADDR_W'(ADC_GATED_ADDR) && !bankQ[PWR_REG][PWR_ADC_BIT])
      |=> $stable(bankQ[ADC_GATED_ADDR]));

  // R9
  pga_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && frameAddr == ADDR_W'(PGA_GATED_ADDR) && !bankQ[PWR_REG][PWR_PGA_BIT])
      |=> $stable(bankQ[PGA_GATED_ADDR]));

  // R7
  cal_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && strobe.calBusy) |=> $stable(bankQ[CAL_ADDR]));

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
#(
  parameter int CAL_PERIODS = 4128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output logic [7:0] cfgReg0,
  output logic [7:0] cfgReg1,
  output logic [7:0] cfgReg2,
  output logic [7:0] cfgReg3,
  output logic       calActive
);

  ctlStrobe_t                       strobe;
  logic [REG_COUNT-1:0][DATA_W-1:0] bankQ;

  serial_cfg_ctrl #(
    .CAL_PERIODS(CAL_PERIODS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .csN       (csN),
    .sclk      (sclk),
    .sdi       (sdi),
    .strobe    (strobe)
  );

  serial_cfg_regs uRegs (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .bankQ (bankQ)
  );

  assign cfgReg0   = bankQ[0];
  assign cfgReg1   = bankQ[1];
  assign cfgReg2   = bankQ[2];
  assign cfgReg3   = bankQ[3];
  assign calActive = strobe.calBusy;

endmodule

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;

  localparam int CAL_N = 4128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [7:0] cfgReg0, cfgReg1, cfgReg2, cfgReg3;
  logic calActive;

  int vecs = 0;
  int errs = 0;
  int tickCount = 0;
  logic [1:0] phase = '0;
  logic [7:0] expReg [4];

  serial_cfg_port dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .csN(csN), .sclk(sclk), .sdi(sdi),
    .cfgReg0(cfgReg0), .cfgReg1(cfgReg1), .cfgReg2(cfgReg2), .cfgReg3(cfgReg3),
    .calActive(calActive)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    phase <= phase + 2'd1;
    sampleTick <= (phase == 2'd3);
    if (!rstN) tickCount <= 0;
    else if (sampleTick) tickCount <= tickCount + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkRegs(input string req);
    chk(req, {cfgReg3, cfgReg2, cfgReg1, cfgReg0},
        {expReg[3], expReg[2], expReg[1], expReg[0]});
  endtask

  task automatic resetModel();
    expReg[0] = 8'h05; expReg[1] = 8'h03; expReg[2] = 8'h30; expReg[3] = 8'h00;
  endtask

  function automatic bit allowed(input logic [4:0] a);
    if (a > 5'd3) return 1'b0;
    if (a == 5'd1) return (tickCount < CAL_N) ? 1'b0 : 1'b1;
    if (a == 5'd2) return expReg[1][1];
    if (a == 5'd3) return expReg[1][0];
    return 1'b1;
  endfunction

  task automatic sendFrame(input logic [2:0] op, input logic [4:0] addr,
                           input logic [7:0] dat, input int edges, input string req);
    logic [15:0] frame;
    bit commit;
    frame = {dat, addr, op};
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < edges; i++) begin
      sdi = (i < 16) ? frame[i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    // R2: nothing may change before select is released
    chkRegs("R2");
    commit = (edges == 16) && op[2] && allowed(addr);
    csN = 1'b1;
    repeat (10) @(negedge clk);
    if (commit) expReg[addr[1:0]] = dat;
    chkRegs(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    resetModel();
    repeat (5) @(negedge clk);
    // R6: values during reset
    chkRegs("R6");
    chk("R7", {31'd0, calActive}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    chkRegs("R6");

    // R7: address 1 locked during calibration, others open
    sendFrame(3'b100, 5'd1, 8'h00, 16, "R7");
    sendFrame(3'b100, 5'd0, 8'hA6, 16, "R7");
    sendFrame(3'b111, 5'd2, 8'h5C, 16, "R1");
    chk("R7", {31'd0, calActive}, 32'd1);

    // R10: clock activity with select high
    for (int i = 0; i < 6; i++) begin
      sdi = i[0];
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (10) @(negedge clk);
    chkRegs("R10");

    // R3: wrong bit counts
    sendFrame(3'b100, 5'd0, 8'h3C, 15, "R3");
    sendFrame(3'b100, 5'd0, 8'hC3, 17, "R3");

    // R7: calibration end boundary
    while (tickCount < CAL_N - 1) @(negedge clk);
    chk("R7", {31'd0, calActive}, 32'd1);
    while (tickCount < CAL_N) @(negedge clk);
    chk("R7", {31'd0, calActive}, 32'd0);
    sendFrame(3'b100, 5'd1, 8'h01, 16, "R7");

    // R8, R9: power gating
    sendFrame(3'b100, 5'd2, 8'h77, 16, "R8");
    sendFrame(3'b100, 5'd3, 8'h44, 16, "R9");
    sendFrame(3'b100, 5'd1, 8'h02, 16, "R1");
    sendFrame(3'b100, 5'd2, 8'h19, 16, "R8");
    sendFrame(3'b100, 5'd3, 8'h91, 16, "R9");
    sendFrame(3'b100, 5'd1, 8'h03, 16, "R1");

    // R1, R4, R5 sweep over every address and opcode
    for (int a = 0; a < 32; a++) begin
      for (int op = 0; op < 8; op++) begin
        string tag;
        if (a > 3) tag = "R5";
        else if (op < 4) tag = "R4";
        else if (a == 2) tag = "R8";
        else if (a == 3) tag = "R9";
        else tag = "R1";
        sendFrame(op[2:0], a[4:0], 8'((a * 29 + op * 53 + 7) & 255), 16, tag);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule